// File: doc/BRIEF.md
# Programmable Enabled Clock Divider

This block derives a slower clock from the fast clock that runs it. A single 32-bit configuration word holds an enable bit and a 9-bit divisor. The output period is the divisor plus one input cycles. A divisor of zero, or a cleared enable, parks the output low. Software reads and writes the word through a plain port with no address: a write strobe, write data and read data.

Software must turn the divider off before it loads a new divisor. The block enforces this rule. A write that would change the divisor of a running divider, while leaving the enable set, keeps the old divisor and raises a sticky error output. Every time the output starts, it opens with a complete low phase, so no runt pulse appears at the handover.

Top module: `pgm_clk_div`

## Requirements
- R1: During and after reset the read data is 0x0000_800F (enable at bit 15 set, divisor 15 in bits 8:0), the error output is low and the output clock is low; after reset release the output runs at input/16.
- R2: With enable set and divisor D (1 to 511), the output period is N = D+1 input cycles; for even N the high and low phases are each N/2 cycles (D=7 gives 4 high, 4 low; D=15 gives 8 high, 8 low).
- R3: With the enable set and a divisor of 0, the output stays low.
- R4: For odd N the high phase lasts floor(N/2) cycles and the low phase lasts ceil(N/2) cycles (D=2 gives 1 high, 2 low; D=4 gives 2 high, 3 low).
- R5: A divisor of 1 gives the fastest output, with 1 cycle high and 1 cycle low.
- R6: Bit 15 of the word is the enable. A write with bit 15 at 0 forces the output low no later than the second rising input edge after the write edge, and the output stays low while the enable is 0.
- R7: A write with bit 15 at 1, made while the stored enable is 1, whose bits 8:0 differ from the stored divisor, leaves the divisor unchanged and sets the error output. The error output stays set until reset. A write of the same divisor while running sets no error.
- R8: Bits 31:16 and 14:9 of the write data are ignored and always read back as 0; bits 8:0 read back the divisor.
- R9: A single write that clears bit 15 and changes bits 8:0 is fully accepted and raises no error.
- R10: When the divider starts (the enable is set with a nonzero divisor), the output is low for exactly ceil(N/2) cycles, counted from the write edge, before it first goes high.

## Ports
| Port | Direction | Width | Description |
|------|-----------|-------|-------------|
| clk | input | 1 | Fast input clock that is divided |
| rst_n | input | 1 | Active-low synchronous reset |
| cfg_we | input | 1 | Write strobe for the configuration word |
| cfg_wdata | input | 32 | Configuration write data |
| cfg_rdata | output | 32 | Configuration read data |
| div_clk_o | output | 1 | Divided output clock |
| cfg_err_o | output | 1 | Sticky flag for an attempted divisor change while running |

## Verification
The bench measures whole high and low phases for even ratios, odd ratios and the fastest ratio. A wrong phase split would show up as an asymmetric or off-by-one period. It holds the output under observation with the divisor at zero and with the divider disabled, where a design that lets the counter free-run would toggle. It also counts the low cycles after each start, which catches a divider that begins mid-phase or emits a runt. It then tries a divisor change while running, a same-value rewrite, and a combined disable-and-change write. A guard that is too strict or too loose would show up as a wrong read-back divisor or a wrong error flag.

// File: rtl/pgm_clk_div_pkg.sv
package pgm_clk_div_pkg;

   localparam int CFG_W       = 32;
   localparam int DIV_W_DEF   = 9;
   localparam int EN_POS_DEF  = 15;
   localparam int RST_DIV_DEF = 15;
   localparam bit RST_EN_DEF  = 1'b1;

   // Mask of the bits that hold state, for a given layout.
   function automatic logic [CFG_W-1:0] live_mask(input int div_w, input int en_pos);
      logic [CFG_W-1:0] m;
      m = '0;
      for (int i = 0; i < div_w; i++) m[i] = 1'b1;
      m[en_pos] = 1'b1;
      return m;
   endfunction

endpackage

// File: rtl/pgm_clk_div_guard.sv
module pgm_clk_div_guard #(
   parameter int DIV_W = 9
) (
   input  logic             cur_en_i,
   input  logic [DIV_W-1:0] cur_div_i,
   input  logic             we_i,
   input  logic             new_en_i,
   input  logic [DIV_W-1:0] new_div_i,
   output logic             div_load_o,
   output logic             violation_o
);

   logic changes_div;
   logic stays_running;

   always_comb begin
      changes_div   = (new_div_i != cur_div_i);
      stays_running = cur_en_i && new_en_i;
      violation_o   = we_i && stays_running && changes_div;
      div_load_o    = we_i && !violation_o;
   end

endmodule

// File: rtl/pgm_clk_div_reg.sv
module pgm_clk_div_reg
   import pgm_clk_div_pkg::*;
#(
   parameter int         DIV_W   = DIV_W_DEF,
   parameter int         EN_POS  = EN_POS_DEF,
   parameter logic       RST_EN  = RST_EN_DEF,
   parameter int         RST_DIV = RST_DIV_DEF
) (
   input  logic             clk,
   input  logic             rst_n,
   input  logic             we_i,
   input  logic             wen_i,
   input  logic [DIV_W-1:0] wdiv_i,
   output logic [CFG_W-1:0] rdata_o,
   output logic             en_o,
   output logic [DIV_W-1:0] div_o,
   output logic             err_o,
   output logic             run_o
);

   localparam logic [DIV_W-1:0] RST_DIV_V = DIV_W'(RST_DIV);

   logic             en_q;
   logic [DIV_W-1:0] div_q;
   logic             err_q;
   logic             div_load;
   logic             violation;

   pgm_clk_div_guard #(.DIV_W(DIV_W)) u_guard (
      .cur_en_i    (en_q),
      .cur_div_i   (div_q),
      .we_i        (we_i),
      .new_en_i    (wen_i),
      .new_div_i   (wdiv_i),
      .div_load_o  (div_load),
      .violation_o (violation)
   );

   always_ff @(posedge clk) begin
      if (!rst_n) begin
         en_q  <= RST_EN;
         div_q <= RST_DIV_V;
         err_q <= 1'b0;
      end else begin
         if (we_i)      en_q  <= wen_i;
         if (div_load)  div_q <= wdiv_i;
         if (violation) err_q <= 1'b1;
      end
   end

   always_comb begin
      rdata_o               = '0;
      rdata_o[EN_POS]       = en_q;
      rdata_o[DIV_W-1:0]    = div_q;
   end

   assign en_o  = en_q;
   assign div_o = div_q;
   assign err_o = err_q;
   assign run_o = en_q && (div_q != '0);

endmodule

// File: rtl/pgm_clk_div_gen.sv
module pgm_clk_div_gen #(
   parameter int DIV_W    = 9,
   parameter bit LONG_LOW = 1'b1
) (
   input  logic             clk,
   input  logic             rst_n,
   input  logic             run_i,
   input  logic [DIV_W-1:0] div_i,
   output logic             clk_o
);

   localparam int RW = DIV_W + 1;

   logic [RW-1:0]    ratio;
   logic [RW-1:0]    half;
   logic [RW-1:0]    low_len;
   logic [DIV_W-1:0] cnt_q;
   logic [DIV_W-1:0] cnt_nxt;
   logic             out_q;

   assign ratio = {1'b0, div_i} + RW'(1);
   assign half  = ratio >> 1;

   generate
      if (LONG_LOW) begin : g_low_long
         assign low_len = ratio - half;
      end else begin : g_low_short
         assign low_len = half;
      end
   endgenerate

   always_comb begin
      if (!run_i)
         cnt_nxt = '0;
      else if (cnt_q >= div_i)
         cnt_nxt = '0;
      else
         cnt_nxt = cnt_q + DIV_W'(1);
   end

   always_ff @(posedge clk) begin
      if (!rst_n) begin
         cnt_q <= '0;
         out_q <= 1'b0;
      end else begin
         cnt_q <= cnt_nxt;
         out_q <= run_i && ({1'b0, cnt_nxt} >= low_len);
      end
   end

   assign clk_o = out_q;

endmodule

// File: rtl/pgm_clk_div.sv
module pgm_clk_div
   import pgm_clk_div_pkg::*;
#(
   parameter int   DIV_W    = DIV_W_DEF,
   parameter int   EN_POS   = EN_POS_DEF,
   parameter logic RST_EN   = RST_EN_DEF,
   parameter int   RST_DIV  = RST_DIV_DEF,
   parameter bit   LONG_LOW = 1'b1
) (
   input  logic             clk,
   input  logic             rst_n,
   input  logic             cfg_we,
   input  logic [CFG_W-1:0] cfg_wdata,
   output logic [CFG_W-1:0] cfg_rdata,
   output logic             div_clk_o,
   output logic             cfg_err_o
);

   localparam logic [CFG_W-1:0] LIVE = live_mask(DIV_W, EN_POS);

   generate
      if (DIV_W < 2 || DIV_W >= EN_POS)
         $error("divisor field must be 2 bits or more and sit below the enable bit");
      if (EN_POS >= CFG_W)
         $error("enable bit outside the configuration word");
      if (RST_DIV < 0 || RST_DIV >= (1 << DIV_W))
         $error("reset divisor does not fit the divisor field");
   endgenerate

   logic             en;
   logic [DIV_W-1:0] div;
   logic             run;
   logic             unused_rsv;

   assign unused_rsv = ^(cfg_wdata & ~LIVE);

   pgm_clk_div_reg #(
      .DIV_W   (DIV_W),
      .EN_POS  (EN_POS),
      .RST_EN  (RST_EN),
      .RST_DIV (RST_DIV)
   ) u_reg (
      .clk     (clk),
      .rst_n   (rst_n),
      .we_i    (cfg_we),
      .wen_i   (cfg_wdata[EN_POS]),
      .wdiv_i  (cfg_wdata[DIV_W-1:0]),
      .rdata_o (cfg_rdata),
      .en_o    (en),
      .div_o   (div),
      .err_o   (cfg_err_o),
      .run_o   (run)
   );

   pgm_clk_div_gen #(
      .DIV_W    (DIV_W),
      .LONG_LOW (LONG_LOW)
   ) u_gen (
      .clk   (clk),
      .rst_n (rst_n),
      .run_i (run),
      .div_i (div),
      .clk_o (div_clk_o)
   );

   logic unused_en;
   assign unused_en = en;

endmodule

// File: rtl/pgm_clk_div_chk.sv
module pgm_clk_div_chk #(
   parameter int DIV_W  = 9
) (
   input logic             clk,
   input logic             rst_n,
   input logic             we,
   input logic             w_en,
   input logic [DIV_W-1:0] w_div,
   input logic             r_en,
   input logic [DIV_W-1:0] r_div,
   input logic             clk_o,
   input logic             err
);

   logic running;
   assign running = r_en && (r_div != '0);

   // R7: divisor kept and flag raised on a change attempted while running
   p_guard_blocks_r7: assert property (@(posedge clk) disable iff (!rst_n)
      (we && r_en && w_en && (w_div != r_div)) |=> (r_div == $past(r_div)) && err);

   // R7: error flag is sticky
   p_err_sticky_r7: assert property (@(posedge clk) disable iff (!rst_n)
      err |=> err);

   // R6: enable follows every write
   p_enable_written_r6: assert property (@(posedge clk) disable iff (!rst_n)
      we |=> (r_en == $past(w_en)));

   // R9: divisor only moves when stopped beforehand or the same write disables
   p_div_moves_safely_r9: assert property (@(posedge clk) disable iff (!rst_n)
      (r_div != $past(r_div)) |-> (!$past(r_en) || !$past(w_en)));

   // R3: output low after two cycles without run
   p_stopped_low_r3: assert property (@(posedge clk) disable iff (!rst_n)
      ($past(!running) && !running) |-> !clk_o);

   // R10: output still low in the cycle the divider starts
   p_start_low_r10: assert property (@(posedge clk) disable iff (!rst_n)
      $rose(running) |-> !clk_o);

   // R2: output rises only while running
   p_rise_needs_run_r2: assert property (@(posedge clk) disable iff (!rst_n)
      $rose(clk_o) |-> $past(running));

endmodule

bind pgm_clk_div pgm_clk_div_chk #(.DIV_W(DIV_W)) u_chk (
   .clk   (clk),
   .rst_n (rst_n),
   .we    (cfg_we),
   .w_en  (cfg_wdata[EN_POS]),
   .w_div (cfg_wdata[DIV_W-1:0]),
   .r_en  (cfg_rdata[EN_POS]),
   .r_div (cfg_rdata[DIV_W-1:0]),
   .clk_o (div_clk_o),
   .err   (cfg_err_o)
);

// File: tb/sim_pgm_clk_div.sv
`timescale 1ns/1ps
module sim_pgm_clk_div;

   logic        clk = 1'b0;
   logic        rst_n = 1'b0;
   logic        cfg_we = 1'b0;
   logic [31:0] cfg_wdata = '0;
   logic [31:0] cfg_rdata;
   logic        div_clk_o;
   logic        cfg_err_o;

   int checks = 0;
   int fails  = 0;
   bit done   = 1'b0;

   always #2.5 clk = ~clk;

   pgm_clk_div u0 (
      .clk       (clk),
      .rst_n     (rst_n),
      .cfg_we    (cfg_we),
      .cfg_wdata (cfg_wdata),
      .cfg_rdata (cfg_rdata),
      .div_clk_o (div_clk_o),
      .cfg_err_o (cfg_err_o)
   );

   task automatic chk(input bit ok, input string req, input string what,
                      input longint act, input longint exp);
      checks++;
      if (!ok) begin
         fails++;
         $display("FAIL %s %s: actual 0x%0h expected 0x%0h", req, what, act, exp);
      end
   endtask

   task automatic wr(input logic [31:0] d);
      @(negedge clk);
      cfg_we    = 1'b1;
      cfg_wdata = d;
      @(negedge clk);
      cfg_we    = 1'b0;
      cfg_wdata = '0;
   endtask

   task automatic measure(input int eh, input int el, input string req);
      int h = 0;
      int l = 0;
      int g = 0;
      while (div_clk_o !== 1'b0 && g < 4000) begin @(negedge clk); g++; end
      while (div_clk_o !== 1'b1 && g < 4000) begin @(negedge clk); g++; end
      while (div_clk_o === 1'b1 && g < 4000) begin h++; @(negedge clk); g++; end
      while (div_clk_o === 1'b0 && g < 4000) begin l++; @(negedge clk); g++; end
      chk(h == eh, req, "high phase", h, eh);
      chk(l == el, req, "low phase", l, el);
   endtask

   task automatic stays_low(input int n, input string req);
      int hi = 0;
      for (int i = 0; i < n; i++) begin
         if (div_clk_o !== 1'b0) hi++;
         @(negedge clk);
      end
      chk(hi == 0, req, "high samples while parked", hi, 0);
   endtask

   task automatic lead_low(input int el, input string req);
      int l = 0;
      while (div_clk_o === 1'b0 && l < 2000) begin l++; @(negedge clk); end
      chk(l == el, req, "first low phase", l, el);
   endtask

   task automatic t_reset;
      rst_n = 1'b0;
      repeat (4) @(negedge clk);
      chk(cfg_rdata == 32'h0000_800F, "R1", "reset word", cfg_rdata, 32'h0000_800F);
      chk(cfg_err_o == 1'b0, "R1", "reset error", cfg_err_o, 0);
      chk(div_clk_o == 1'b0, "R1", "output in reset", div_clk_o, 0);
      rst_n = 1'b1;
      measure(8, 8, "R1");
   endtask

   task automatic t_div7;
      wr(32'h0000_0000);
      wr(32'h0000_0007);
      wr(32'h0000_8007);
      chk(cfg_rdata == 32'h0000_8007, "R2", "word", cfg_rdata, 32'h0000_8007);
      measure(4, 4, "R2");
      chk(cfg_err_o == 1'b0, "R2", "no error", cfg_err_o, 0);
   endtask

   task automatic t_odd;
      wr(32'h0000_0002);
      wr(32'h0000_8002);
      measure(1, 2, "R4");
      wr(32'h0000_0004);
      wr(32'h0000_8004);
      measure(2, 3, "R4");
   endtask

   task automatic t_fast;
      wr(32'h0000_0001);
      wr(32'h0000_8001);
      measure(1, 1, "R5");
   endtask

   task automatic t_zero;
      wr(32'h0000_0000);
      wr(32'h0000_8000);
      chk(cfg_rdata == 32'h0000_8000, "R3", "word", cfg_rdata, 32'h0000_8000);
      stays_low(64, "R3");
   endtask

   task automatic t_disable;
      wr(32'h0000_0007);
      stays_low(64, "R6");
      wr(32'h0000_8007);
      while (div_clk_o !== 1'b1) @(negedge clk);
      wr(32'h0000_0007);
      @(negedge clk);
      stays_low(40, "R6");
   endtask

   task automatic t_restart;
      wr(32'h0000_8007);
      lead_low(4, "R10");
      wr(32'h0000_0002);
      wr(32'h0000_8002);
      lead_low(2, "R10");
   endtask

   task automatic t_reserved;
      wr(32'h0000_0000);
      wr(32'hFFFF_7E05);
      chk(cfg_rdata == 32'h0000_0005, "R8", "reserved dropped", cfg_rdata, 32'h0000_0005);
      wr(32'hFFFF_FE05);
      chk(cfg_rdata == 32'h0000_8005, "R8", "reserved dropped, enabled", cfg_rdata, 32'h0000_8005);
      measure(3, 3, "R8");
   endtask

   task automatic t_clear_change;
      wr(32'h0000_8005);
      chk(cfg_err_o == 1'b0, "R7", "same divisor rewrite", cfg_err_o, 0);
      wr(32'h0000_0009);
      chk(cfg_rdata == 32'h0000_0009, "R9", "combined write", cfg_rdata, 32'h0000_0009);
      chk(cfg_err_o == 1'b0, "R9", "no error", cfg_err_o, 0);
   endtask

   task automatic t_guard;
      wr(32'h0000_0007);
      wr(32'h0000_8007);
      wr(32'h0000_8003);
      chk(cfg_rdata == 32'h0000_8007, "R7", "divisor kept", cfg_rdata, 32'h0000_8007);
      chk(cfg_err_o == 1'b1, "R7", "error raised", cfg_err_o, 1);
      measure(4, 4, "R7");
      wr(32'h0000_0003);
      wr(32'h0000_8003);
      chk(cfg_rdata == 32'h0000_8003, "R7", "legal reload", cfg_rdata, 32'h0000_8003);
      chk(cfg_err_o == 1'b1, "R7", "error sticky", cfg_err_o, 1);
   endtask

   task automatic report;
      $display("%0d/%0d checks passed", checks - fails, checks);
      $finish;
   endtask

   initial begin
      @(negedge clk);
      t_reset;
      t_div7;
      t_odd;
      t_fast;
      t_zero;
      t_disable;
      t_restart;
      t_reserved;
      t_clear_change;
      t_guard;
      done = 1'b1;
      report;
   end

   initial begin
      repeat (200000) @(posedge clk);
      if (!done) begin
         checks++;
         fails++;
         $display("FAIL watchdog: actual timeout expected completion");
         report;
      end
   end

endmodule